// File: doc/BRIEF.md
# Region Capacity Manager

This controller decides when a warp may enter its next code region. Each region arrives with compiler-supplied metadata: a short list of input register numbers, a flag per input saying whether that value already sits in the staging store, and the peak number of registers the region keeps live at once. From this the block works out how many slots the region needs in each bank of the staging store. It admits the region only when every bank has room. It then asks for the missing inputs to be preloaded and holds the warp off the issue stage until all of those preloads have returned.

Inputs are charged to the bank given by their register number. Interior registers, which need space but no fetch, are spread evenly across the banks. Admission is all-or-nothing: either the whole demand is taken from the shared per-bank free counters, or nothing is taken and the request stays pending. When the warp finishes the region, the slots it held go back to the free counters. Warps with pending admissions are served round-robin, at most one per cycle. Preload requests also go out one per cycle, round-robin across warps.

Top module: `region_capacity_manager`

## Requirements
- R1: After reset every free counter equals BANK_CAP, no warp is ready, no warp is acknowledged, no preload is requested and the error flag is low.
- R2: A region's demand on bank b is the number of its valid inputs whose register number modulo NUM_BANKS equals b, plus an interior share. The interior count is max(live − valid inputs, 0). Interior k is charged to bank k modulo NUM_BANKS. On admission each bank's free count drops by exactly that demand.
- R3: A region whose demand exceeds the free count of any bank is not acknowledged and reserves nothing. It is acknowledged in the first cycle in which every bank covers it.
- R4: At most one region is acknowledged per cycle (meta_ack_o is combinational in the request cycle). Among eligible warps, the search starts just after the last acknowledged warp, and the pointer starts at warp 0 after reset.
- R5: After admission, one preload request goes out for each valid input not flagged resident, in ascending slot order, carrying the warp index and the register number. Inputs flagged resident produce no request.
- R6: A preload request that is not accepted keeps its warp and register unchanged in the next cycle.
- R7: ready_o of a warp rises in the cycle after the edge on which its last outstanding preload response is taken. If the region has no preloads, it rises in the cycle after admission. It stays low while any of that warp's preloads is pending or outstanding.
- R8: A completion on a ready warp returns that warp's per-bank holdings to the free counters (saturating at BANK_CAP), drops ready_o and lets the warp be admitted again. Free counts never rise without a completion.
- R9: A preload response for a warp with nothing outstanding, or a completion for a warp that is not ready, sets the sticky error flag and changes no counter or ready output.
- R10: A metadata request on a warp that already holds a region is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meta_valid_i | input | NUM_WARPS | Warp requests admission of its next region |
| meta_in_mask_i | input | NUM_WARPS*MAX_IN | Valid input slots, MAX_IN bits per warp |
| meta_in_reg_i | input | NUM_WARPS*MAX_IN*REG_W | Input register numbers, slot i of warp w at bits (w*MAX_IN+i)*REG_W |
| meta_in_res_i | input | NUM_WARPS*MAX_IN | Input already resident, no preload needed |
| meta_live_i | input | NUM_WARPS*LIVE_W | Peak live register count of the region |
| meta_ack_o | output | NUM_WARPS | One-hot admission acknowledge |
| pre_req_valid_o | output | 1 | Preload request valid |
| pre_req_ready_i | input | 1 | Preload request accepted |
| pre_req_warp_o | output | WID_W | Warp of the preload request |
| pre_req_reg_o | output | REG_W | Register to preload |
| pre_rsp_valid_i | input | 1 | A preload has returned |
| pre_rsp_warp_i | input | WID_W | Warp of the returned preload |
| done_valid_i | input | 1 | A warp has completed its region |
| done_warp_i | input | WID_W | Warp that completed |
| ready_o | output | NUM_WARPS | Warp may issue |
| free_o | output | NUM_BANKS*CNT_W | Free slot count per bank |
| err_o | output | 1 | Sticky protocol error flag |

## Verification
The bound checker watches on every cycle that acknowledges are one-hot and only go to requesting, non-ready warps, and that free counts stay within capacity. It also watches that they fall only on an acknowledge and rise only on a completion, that a stalled preload request holds still, and that no preload is ever requested for a warp already marked ready. The exact per-bank arithmetic, the slot order of preloads, the timing of ready_o, the round-robin order, the retry after a refusal and the error cases can only be shown by the bench. It sweeps every input mask and live count over two register layouts and two residency patterns, and compares against demands computed from the mapping rule.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FETCH = 2'd1,
    WS_READY = 2'd2
  } warp_state_e;

  // slots of n_int interiors that land on a bank, filling banks from 0 upward
  function automatic int interior_share(int n_int, int n_banks, int bank);
    return n_int / n_banks + ((bank < (n_int % n_banks)) ? 1 : 0);
  endfunction

endpackage

// File: rtl/rcm_rr_arb.sv
module rcm_rr_arb #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             adv_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);

  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    int j;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr_q) + k) % N;
      if (!gnt_valid_o && req_i[j]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDX_W'(j);
      end
    end
  end

  // a stalled grant keeps top priority so the winner cannot change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (gnt_valid_o) begin
      ptr_q <= adv_i ? IDX_W'((int'(gnt_idx_o) + 1) % N) : gnt_idx_o;
    end
  end

endmodule

// File: rtl/rcm_demand.sv
module rcm_demand
  import rcm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int MAX_IN    = 4,
  parameter int REG_W     = 4,
  parameter int LIVE_W    = 4,
  parameter int DEM_W     = 4,
  parameter int CNT_W     = 3
) (
  input  logic [MAX_IN-1:0]                in_mask_i,
  input  logic [MAX_IN-1:0][REG_W-1:0]     in_reg_i,
  input  logic [MAX_IN-1:0]                in_res_i,
  input  logic [LIVE_W-1:0]                live_i,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0]  free_i,
  output logic [NUM_BANKS-1:0][DEM_W-1:0]  dem_o,
  output logic [MAX_IN-1:0]                pre_o,
  output logic                             fits_o
);

  always_comb begin
    int n_in;
    int n_int;
    int d;
    n_in = 0;
    for (int i = 0; i < MAX_IN; i++) n_in += int'(in_mask_i[i]);
    n_int  = (int'(live_i) > n_in) ? int'(live_i) - n_in : 0;
    fits_o = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      d = interior_share(n_int, NUM_BANKS, b);
      for (int i = 0; i < MAX_IN; i++) begin
        if (in_mask_i[i] && ((int'(in_reg_i[i]) % NUM_BANKS) == b)) d++;
      end
      dem_o[b] = DEM_W'(d);
      if (d > int'(free_i[b])) fits_o = 1'b0;
    end
    pre_o = in_mask_i & ~in_res_i;
  end

endmodule

// File: rtl/rcm_warp_ctx.sv
module rcm_warp_ctx
  import rcm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int MAX_IN    = 4,
  parameter int REG_W     = 4,
  parameter int BANK_CAP  = 4,
  parameter int CNT_W     = 3,
  parameter int DEM_W     = 4,
  parameter int OUT_W     = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            admit_i,
  input  logic [MAX_IN-1:0]               adm_pre_i,
  input  logic [MAX_IN-1:0][REG_W-1:0]    adm_reg_i,
  input  logic [NUM_BANKS-1:0][DEM_W-1:0] adm_dem_i,
  input  logic                            issue_i,
  input  logic                            rsp_i,
  input  logic                            done_i,
  output logic                            idle_o,
  output logic                            ready_o,
  output logic                            busy_o,
  output logic [REG_W-1:0]                issue_reg_o,
  output logic [NUM_BANKS-1:0][CNT_W-1:0] active_o,
  output logic                            err_o
);

  warp_state_e                     st_q, st_d;
  logic [MAX_IN-1:0]               pend_q, pend_d;
  logic [MAX_IN-1:0][REG_W-1:0]    regs_q, regs_d;
  logic [OUT_W-1:0]                out_q, out_d;
  logic [NUM_BANKS-1:0][CNT_W-1:0] act_q, act_d;

  // lowest pending slot goes first
  always_comb begin
    issue_reg_o = '0;
    for (int i = MAX_IN - 1; i >= 0; i--) begin
      if (pend_q[i]) issue_reg_o = regs_q[i];
    end
  end

  always_comb begin
    int o;
    st_d   = st_q;
    pend_d = pend_q;
    regs_d = regs_q;
    out_d  = out_q;
    act_d  = act_q;
    err_o  = 1'b0;
    o      = int'(out_q);
    unique case (st_q)
      WS_IDLE: begin
        if (rsp_i || done_i) err_o = 1'b1;
        if (admit_i) begin
          pend_d = adm_pre_i;
          regs_d = adm_reg_i;
          out_d  = '0;
          for (int b = 0; b < NUM_BANKS; b++) begin
            act_d[b] = (int'(adm_dem_i[b]) > BANK_CAP) ? CNT_W'(BANK_CAP)
                                                       : CNT_W'(adm_dem_i[b]);
          end
          st_d = (adm_pre_i == '0) ? WS_READY : WS_FETCH;
        end
      end
      WS_FETCH: begin
        if (done_i) err_o = 1'b1;
        if (issue_i) begin
          pend_d = pend_q & (pend_q - 1'b1);
          o++;
        end
        if (rsp_i) begin
          if (o == 0) err_o = 1'b1;
          else        o--;
        end
        out_d = OUT_W'(o);
        if (pend_d == '0 && o == 0) st_d = WS_READY;
      end
      WS_READY: begin
        if (rsp_i) err_o = 1'b1;
        if (done_i) begin
          st_d  = WS_IDLE;
          act_d = '0;
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WS_IDLE;
      pend_q <= '0;
      regs_q <= '0;
      out_q  <= '0;
      act_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      regs_q <= regs_d;
      out_q  <= out_d;
      act_q  <= act_d;
    end
  end

  assign idle_o   = (st_q == WS_IDLE);
  assign ready_o  = (st_q == WS_READY);
  assign busy_o   = |pend_q;
  assign active_o = act_q;

endmodule

// File: rtl/region_capacity_manager.sv
module region_capacity_manager
  import rcm_pkg::*;
#(
  parameter int  NUM_WARPS = 4,
  parameter int  NUM_BANKS = 4,
  parameter int  BANK_CAP  = 4,
  parameter int  MAX_IN    = 4,
  parameter int  MAX_LIVE  = 8,
  parameter int  REG_W     = 4,
  localparam int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int CNT_W     = $clog2(BANK_CAP + 1),
  localparam int LIVE_W    = $clog2(MAX_LIVE + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_WARPS-1:0]              meta_valid_i,
  input  logic [NUM_WARPS*MAX_IN-1:0]       meta_in_mask_i,
  input  logic [NUM_WARPS*MAX_IN*REG_W-1:0] meta_in_reg_i,
  input  logic [NUM_WARPS*MAX_IN-1:0]       meta_in_res_i,
  input  logic [NUM_WARPS*LIVE_W-1:0]       meta_live_i,
  output logic [NUM_WARPS-1:0]              meta_ack_o,
  output logic                              pre_req_valid_o,
  input  logic                              pre_req_ready_i,
  output logic [WID_W-1:0]                  pre_req_warp_o,
  output logic [REG_W-1:0]                  pre_req_reg_o,
  input  logic                              pre_rsp_valid_i,
  input  logic [WID_W-1:0]                  pre_rsp_warp_i,
  input  logic                              done_valid_i,
  input  logic [WID_W-1:0]                  done_warp_i,
  output logic [NUM_WARPS-1:0]              ready_o,
  output logic [NUM_BANKS*CNT_W-1:0]        free_o,
  output logic                              err_o
);

  localparam int DEM_W = $clog2(MAX_LIVE + MAX_IN + 1);
  localparam int OUT_W = $clog2(MAX_IN + 1);

  logic [NUM_WARPS-1:0][MAX_IN-1:0]            in_mask, in_res, pre;
  logic [NUM_WARPS-1:0][MAX_IN-1:0][REG_W-1:0] in_reg;
  logic [NUM_WARPS-1:0][LIVE_W-1:0]            live;
  logic [NUM_WARPS-1:0][NUM_BANKS-1:0][DEM_W-1:0] dem;
  logic [NUM_WARPS-1:0][NUM_BANKS-1:0][CNT_W-1:0] active;
  logic [NUM_WARPS-1:0][REG_W-1:0]             issue_reg;
  logic [NUM_WARPS-1:0] fits, idle, rdy, busy, werr;
  logic [NUM_WARPS-1:0] adm_req, admit, issue, rsp, done;
  logic [NUM_BANKS-1:0][CNT_W-1:0] free_q, free_d;
  logic             adm_gv, pre_gv, err_q;
  logic [WID_W-1:0] adm_idx, pre_idx;

  assign in_mask = meta_in_mask_i;
  assign in_res  = meta_in_res_i;
  assign in_reg  = meta_in_reg_i;
  assign live    = meta_live_i;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    rcm_demand #(
      .NUM_BANKS(NUM_BANKS), .MAX_IN(MAX_IN), .REG_W(REG_W),
      .LIVE_W(LIVE_W), .DEM_W(DEM_W), .CNT_W(CNT_W)
    ) u_dem (
      .in_mask_i(in_mask[w]),
      .in_reg_i (in_reg[w]),
      .in_res_i (in_res[w]),
      .live_i   (live[w]),
      .free_i   (free_q),
      .dem_o    (dem[w]),
      .pre_o    (pre[w]),
      .fits_o   (fits[w])
    );

    rcm_warp_ctx #(
      .NUM_BANKS(NUM_BANKS), .MAX_IN(MAX_IN), .REG_W(REG_W),
      .BANK_CAP(BANK_CAP), .CNT_W(CNT_W), .DEM_W(DEM_W), .OUT_W(OUT_W)
    ) u_ctx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .admit_i    (admit[w]),
      .adm_pre_i  (pre[w]),
      .adm_reg_i  (in_reg[w]),
      .adm_dem_i  (dem[w]),
      .issue_i    (issue[w]),
      .rsp_i      (rsp[w]),
      .done_i     (done[w]),
      .idle_o     (idle[w]),
      .ready_o    (rdy[w]),
      .busy_o     (busy[w]),
      .issue_reg_o(issue_reg[w]),
      .active_o   (active[w]),
      .err_o      (werr[w])
    );

    assign adm_req[w] = meta_valid_i[w] & idle[w] & fits[w];
    assign admit[w]   = adm_gv && (adm_idx == WID_W'(w));
    assign issue[w]   = pre_gv && pre_req_ready_i && (pre_idx == WID_W'(w));
    assign rsp[w]     = pre_rsp_valid_i && (pre_rsp_warp_i == WID_W'(w));
    assign done[w]    = done_valid_i && (done_warp_i == WID_W'(w));
  end

  // only regions that fit compete, so a blocked warp never costs a slot
  rcm_rr_arb #(.N(NUM_WARPS), .IDX_W(WID_W)) u_adm_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (adm_req),
    .adv_i      (1'b1),
    .gnt_valid_o(adm_gv),
    .gnt_idx_o  (adm_idx)
  );

  rcm_rr_arb #(.N(NUM_WARPS), .IDX_W(WID_W)) u_pre_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (busy),
    .adv_i      (pre_req_ready_i),
    .gnt_valid_o(pre_gv),
    .gnt_idx_o  (pre_idx)
  );

  always_comb begin
    int f;
    for (int b = 0; b < NUM_BANKS; b++) begin
      f = int'(free_q[b]);
      for (int w = 0; w < NUM_WARPS; w++) begin
        if (admit[w]) f -= int'(dem[w][b]);
        if (done[w] && rdy[w]) f += int'(active[w][b]);
      end
      if (f > BANK_CAP) f = BANK_CAP;
      if (f < 0) f = 0;
      free_d[b] = CNT_W'(f);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) free_q[b] <= CNT_W'(BANK_CAP);
      err_q <= 1'b0;
    end else begin
      free_q <= free_d;
      err_q  <= err_q | (|werr);
    end
  end

  assign meta_ack_o      = admit;
  assign pre_req_valid_o = pre_gv;
  assign pre_req_warp_o  = pre_idx;
  assign pre_req_reg_o   = issue_reg[pre_idx];
  assign ready_o         = rdy;
  assign free_o          = free_q;
  assign err_o           = err_q;

endmodule

// File: rtl/rcm_checker.sv
module rcm_checker #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_BANKS = 4,
  parameter int BANK_CAP  = 4,
  parameter int REG_W     = 4,
  parameter int WID_W     = 2,
  parameter int CNT_W     = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_WARPS-1:0]       meta_valid_i,
  input logic [NUM_WARPS-1:0]       meta_ack_o,
  input logic [NUM_WARPS-1:0]       ready_o,
  input logic                       pre_req_valid_o,
  input logic                       pre_req_ready_i,
  input logic [WID_W-1:0]           pre_req_warp_o,
  input logic [REG_W-1:0]           pre_req_reg_o,
  input logic                       done_valid_i,
  input logic [NUM_BANKS*CNT_W-1:0] free_o
);

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(meta_ack_o)); // R4

  AST_ACK_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meta_ack_o & ~meta_valid_i) == '0); // R4

  AST_ACK_NOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meta_ack_o & ready_o) == '0); // R10

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_valid_o && !pre_req_ready_i |=>
      pre_req_valid_o && $stable(pre_req_warp_o) && $stable(pre_req_reg_o)); // R6

  AST_NO_PRELOAD_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_valid_o |-> !ready_o[pre_req_warp_o]); // R7

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    AST_FREE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(free_o[b*CNT_W +: CNT_W]) <= BANK_CAP); // R8

    AST_FREE_RISE_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_valid_i |=> free_o[b*CNT_W +: CNT_W] <= $past(free_o[b*CNT_W +: CNT_W])); // R8

    AST_FREE_DROP_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      meta_ack_o == '0 |=> free_o[b*CNT_W +: CNT_W] >= $past(free_o[b*CNT_W +: CNT_W])); // R3
  end

endmodule

bind region_capacity_manager rcm_checker #(
  .NUM_WARPS(NUM_WARPS), .NUM_BANKS(NUM_BANKS), .BANK_CAP(BANK_CAP),
  .REG_W(REG_W), .WID_W(WID_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/region_capacity_manager_tb.sv
module region_capacity_manager_tb;

  localparam int NW = 4, NB = 4, CAP = 4, MI = 4, RW = 4, LW = 4, CW = 3, WW = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NW-1:0]       meta_valid_i = '0;
  logic [NW*MI-1:0]    meta_in_mask_i = '0;
  logic [NW*MI*RW-1:0] meta_in_reg_i = '0;
  logic [NW*MI-1:0]    meta_in_res_i = '0;
  logic [NW*LW-1:0]    meta_live_i = '0;
  logic [NW-1:0]       meta_ack_o;
  logic                pre_req_valid_o;
  logic                pre_req_ready_i = 1'b0;
  logic [WW-1:0]       pre_req_warp_o;
  logic [RW-1:0]       pre_req_reg_o;
  logic                pre_rsp_valid_i = 1'b0;
  logic [WW-1:0]       pre_rsp_warp_i = '0;
  logic                done_valid_i = 1'b0;
  logic [WW-1:0]       done_warp_i = '0;
  logic [NW-1:0]       ready_o;
  logic [NB*CW-1:0]    free_o;
  logic                err_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  region_capacity_manager u_dut (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int free_of(int b);
    return int'(free_o[b*CW +: CW]);
  endfunction

  function automatic int dem_of(logic [3:0] mask, logic [15:0] regs, int live, int b);
    int n, ni, d;
    n = 0;
    for (int i = 0; i < MI; i++) n += int'(mask[i]);
    ni = (live > n) ? live - n : 0;
    d = ni / NB + ((b < ni % NB) ? 1 : 0);
    for (int i = 0; i < MI; i++)
      if (mask[i] && (int'(regs[i*4 +: 4]) % NB) == b) d++;
    return d;
  endfunction

  task automatic set_meta(int w, logic [3:0] mask, logic [15:0] regs, logic [3:0] res, int live);
    meta_in_mask_i[w*MI +: MI] = mask;
    meta_in_res_i[w*MI +: MI]  = res;
    meta_live_i[w*LW +: LW]    = LW'(live);
    for (int i = 0; i < MI; i++) meta_in_reg_i[(w*MI+i)*RW +: RW] = regs[i*4 +: 4];
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(ready_o == '0, "R1 ready", int'(ready_o), 0);
    chk(meta_ack_o == '0, "R1 ack", int'(meta_ack_o), 0);
    chk(!pre_req_valid_o, "R1 preload", int'(pre_req_valid_o), 0);
    chk(!err_o, "R1 err", int'(err_o), 0);
    for (int b = 0; b < NB; b++) chk(free_of(b) == CAP, "R1 free", free_of(b), CAP);
  endtask

  task automatic finish_warp(int w);
    @(negedge clk_i);
    done_valid_i = 1'b1;
    done_warp_i  = WW'(w);
    @(negedge clk_i);
    done_valid_i = 1'b0;
    #1;
    chk(!ready_o[w], "R8 ready drop", int'(ready_o[w]), 0);
  endtask

  task automatic run_region(int w, logic [3:0] mask, logic [15:0] regs, logic [3:0] res, int live);
    int  d[NB];
    bit  fit;
    fit = 1'b1;
    for (int b = 0; b < NB; b++) begin
      d[b] = dem_of(mask, regs, live, b);
      if (d[b] > CAP) fit = 1'b0;
    end
    @(negedge clk_i);
    set_meta(w, mask, regs, res, live);
    meta_valid_i[w] = 1'b1;
    #1;
    chk(meta_ack_o[w] == fit, "R3 admit decision", int'(meta_ack_o[w]), int'(fit));
    if (!fit) begin
      repeat (2) begin
        @(negedge clk_i);
        #1;
        chk(meta_ack_o == '0, "R3 refused", int'(meta_ack_o), 0);
        for (int b = 0; b < NB; b++) chk(free_of(b) == CAP, "R3 nothing reserved", free_of(b), CAP);
      end
      meta_valid_i[w] = 1'b0;
      return;
    end
    @(negedge clk_i);
    meta_valid_i[w] = 1'b0;
    #1;
    for (int b = 0; b < NB; b++) chk(free_of(b) == CAP - d[b], "R2 bank demand", free_of(b), CAP - d[b]);
    for (int i = 0; i < MI; i++) begin
      if (mask[i] && !res[i]) begin
        chk(!ready_o[w], "R7 gated", int'(ready_o[w]), 0);
        chk(pre_req_valid_o && pre_req_warp_o == WW'(w) && pre_req_reg_o == regs[i*4 +: 4],
            "R5 preload", int'(pre_req_reg_o), int'(regs[i*4 +: 4]));
        @(negedge clk_i);
        #1;
        chk(pre_req_valid_o && pre_req_reg_o == regs[i*4 +: 4], "R6 hold", int'(pre_req_reg_o),
            int'(regs[i*4 +: 4]));
        pre_req_ready_i = 1'b1;
        @(negedge clk_i);
        pre_req_ready_i = 1'b0;
        pre_rsp_valid_i = 1'b1;
        pre_rsp_warp_i  = WW'(w);
        #1;
        chk(!ready_o[w], "R7 outstanding", int'(ready_o[w]), 0);
        @(negedge clk_i);
        pre_rsp_valid_i = 1'b0;
        #1;
      end
    end
    chk(!pre_req_valid_o, "R5 no extra preload", int'(pre_req_valid_o), 0);
    chk(ready_o[w], "R7 ready", int'(ready_o[w]), 1);
    finish_warp(w);
    for (int b = 0; b < NB; b++) chk(free_of(b) == CAP, "R8 returned", free_of(b), CAP);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    apply_reset();

    // R4: all warps request one interior each on bank 0
    @(negedge clk_i);
    for (int w = 0; w < NW; w++) set_meta(w, 4'h0, 16'h0, 4'h0, 1);
    meta_valid_i = '1;
    for (int k = 0; k < NW; k++) begin
      #1;
      chk(meta_ack_o == NW'(1 << k), "R4 order", int'(meta_ack_o), 1 << k);
      @(negedge clk_i);
      meta_valid_i[k] = 1'b0;
    end
    #1;
    chk(free_of(0) == 0, "R2 interiors bank0", free_of(0), 0);
    chk(free_of(1) == CAP, "R2 interiors bank1", free_of(1), CAP);
    chk(ready_o == '1, "R7 no preload ready", int'(ready_o), 15);
    for (int w = 0; w < NW; w++) finish_warp(w);
    @(negedge clk_i);
    meta_valid_i = 4'b0110;
    #1;
    chk(meta_ack_o == 4'b0010, "R4 rotate first", int'(meta_ack_o), 2);
    @(negedge clk_i);
    meta_valid_i[1] = 1'b0;
    #1;
    chk(meta_ack_o == 4'b0100, "R4 rotate second", int'(meta_ack_o), 4);
    @(negedge clk_i);
    meta_valid_i[2] = 1'b0;
    finish_warp(1);
    finish_warp(2);

    // R3 and R10: contention on bank 0
    @(negedge clk_i);
    set_meta(0, 4'h0, 16'h0, 4'h0, 4);
    meta_valid_i[0] = 1'b1;
    @(negedge clk_i);
    meta_valid_i[0] = 1'b0;
    #1;
    for (int b = 0; b < NB; b++) chk(free_of(b) == CAP - 1, "R2 spread", free_of(b), CAP - 1);
    chk(ready_o[0], "R7 ready", int'(ready_o[0]), 1);
    meta_valid_i[0] = 1'b1;
    #1;
    chk(meta_ack_o == '0, "R10 held warp", int'(meta_ack_o), 0);
    @(negedge clk_i);
    #1;
    chk(meta_ack_o == '0, "R10 held warp again", int'(meta_ack_o), 0);
    chk(free_of(0) == CAP - 1, "R10 no reserve", free_of(0), CAP - 1);
    meta_valid_i[0] = 1'b0;
    set_meta(1, 4'hF, {4'd12, 4'd8, 4'd4, 4'd0}, 4'hF, 4);
    meta_valid_i[1] = 1'b1;
    #1;
    chk(meta_ack_o == '0, "R3 blocked", int'(meta_ack_o), 0);
    @(negedge clk_i);
    #1;
    chk(meta_ack_o == '0, "R3 still blocked", int'(meta_ack_o), 0);
    chk(free_of(0) == CAP - 1, "R3 no partial", free_of(0), CAP - 1);
    done_valid_i = 1'b1;
    done_warp_i  = 2'd0;
    @(negedge clk_i);
    done_valid_i = 1'b0;
    #1;
    chk(meta_ack_o == 4'b0010, "R3 retry", int'(meta_ack_o), 2);
    @(negedge clk_i);
    meta_valid_i[1] = 1'b0;
    #1;
    chk(free_of(0) == 0, "R2 inputs bank0", free_of(0), 0);
    chk(free_of(3) == CAP, "R2 inputs bank3", free_of(3), CAP);
    chk(ready_o[1] && !pre_req_valid_o, "R5 resident", int'(pre_req_valid_o), 0);
    finish_warp(1);

    // sweep: two layouts, two residency patterns, every mask and live count
    for (int s = 0; s < 2; s++) begin
      for (int r = 0; r < 2; r++) begin
        for (int lv = 0; lv <= 8; lv++) begin
          for (int m = 0; m < 16; m++) begin
            run_region((m + lv) % NW, 4'(m),
                       (s == 0) ? {4'd15, 4'd10, 4'd5, 4'd0} : {4'd12, 4'd8, 4'd4, 4'd0},
                       (r == 0) ? 4'h0 : 4'hA, lv);
          end
        end
      end
    end

    // R9: protocol errors
    finish_warp(2);
    #1;
    chk(err_o, "R9 done on idle", int'(err_o), 1);
    for (int b = 0; b < NB; b++) chk(free_of(b) == CAP, "R9 free untouched", free_of(b), CAP);
    apply_reset();
    @(negedge clk_i);
    pre_rsp_valid_i = 1'b1;
    pre_rsp_warp_i  = 2'd1;
    @(negedge clk_i);
    pre_rsp_valid_i = 1'b0;
    #1;
    chk(err_o, "R9 stray response", int'(err_o), 1);
    chk(ready_o == '0, "R9 ready untouched", int'(ready_o), 0);
    @(negedge clk_i);
    #1;
    chk(err_o, "R9 sticky", int'(err_o), 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule